// File: doc/BRIEF.md
# I2C Controller Interrupt Status Unit

This block collects the event sources of an I2C controller that has a master side and a slave side, and turns them into two level-sensitive interrupt lines, one for each side. Each side has three registers. A sticky raw status register records events. A mask register selects which raw bits may reach the line. A write-one-to-clear register acknowledges events. Software reads and writes these registers over a simple register bus: one address, one write strobe, one read strobe, and combinational read data.

The byte engine, the clock generator and the arbitration logic sit outside this block. They report to it through single-cycle pulses: master transfer finished (with no-acknowledge and arbitration-lost qualifiers), slave byte received (with a first-byte qualifier), and slave transmit data wanted. The block also keeps a slave control word with three flags: receive-request, transmit-request and first-byte-received. Reading or writing the slave data register clears these flags. The block watches the bus SDA and SCL lines through synchronizers, so it can raise START and STOP events on its own.

Top module: `i2c_irq_unit`

Register selection uses the low four address bits; any higher address bit set selects nothing. The registers are:

| Address | Register | Access |
|---|---|---|
| 0 | master raw | read |
| 1 | master mask | read/write |
| 2 | master clear | write one to clear, reads 0 |
| 3 | master status, bit0 = error | read |
| 4 | slave raw | read |
| 5 | slave mask | read/write |
| 6 | slave clear | write one to clear, reads 0 |
| 7 | slave flags: bit0 = receive-request, bit1 = transmit-request, bit2 = first-byte | read |
| 8 | slave data | read / write |

## Requirements
- R1: After reset, every raw, mask, status and flag bit reads 0, and both m_irq and s_irq are low.
- R2: A pulse on m_done sets master raw bit0 (transfer done). If m_nack or m_arb_lost is high in the same cycle, master raw bit1 (error) is also set. Master status bit0 then holds the error outcome (m_nack OR m_arb_lost) of the most recent m_done.
- R3: The slave raw bits are set as follows: bit0 by s_rx_byte, bit1 by s_tx_req, bit2 by a detected START, and bit3 by a detected STOP.
- R4: After both lines pass through the synchronizer, a START is SDA falling while SCL stays high, and a STOP is SDA rising while SCL stays high. An SDA edge while SCL is low sets neither bit.
- R5: A raw register reads back its latched events whatever the mask holds. The mask register stores the written value, and a 1 enables the matching cause.
- R6: m_irq is high exactly when (master raw AND master mask) is nonzero. s_irq is high exactly when (slave raw AND slave mask) is nonzero. The two sides do not affect each other.
- R7: Writing the clear register clears each raw bit whose written bit is 1. Bits written as 0 are unchanged. The clear registers read as 0.
- R8: When an event and a clear write for the same raw bit fall in the same cycle, the bit stays set.
- R9: s_rx_byte sets receive-request (flag bit0). If s_rx_first is high in that same cycle, first-byte (flag bit2) is set in the same cycle. If s_rx_first is low, first-byte is not set.
- R10: A read of the slave data register clears receive-request and first-byte. A write to it clears transmit-request (flag bit1, set by s_tx_req). If a set pulse arrives in the same cycle as its clearing access, the flag stays set.
- R11: A read of the slave data register returns s_rx_data. A write to it updates s_tx_data on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (needed for data-read side effects) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from address |
| m_done | input | 1 | Master transfer finished pulse |
| m_nack | input | 1 | Qualifier of m_done: no acknowledge |
| m_arb_lost | input | 1 | Qualifier of m_done: arbitration lost |
| s_rx_byte | input | 1 | Slave byte received pulse |
| s_rx_first | input | 1 | Qualifier of s_rx_byte: first byte of transfer |
| s_rx_data | input | DATA_W | Received byte from the slave engine |
| s_tx_req | input | 1 | Slave transmit data wanted pulse |
| s_tx_data | output | DATA_W | Byte written by software for the slave engine |
| sda_in | input | 1 | Asynchronous SDA line level |
| scl_in | input | 1 | Asynchronous SCL line level |
| m_irq | output | 1 | Master interrupt line |
| s_irq | output | 1 | Slave interrupt line |

## Verification
The bench builds the unit with its defaults: a 4-bit address, an 8-bit data path and a two-stage synchronizer. With these settings the master side has 2 causes and the slave side has 4. This makes every raw pattern against every mask pattern reachable. The bench sweeps all 16 master combinations and all 256 slave combinations, and compares both lines and the raw readback with arithmetic expectations. All four no-acknowledge/arbitration-lost qualifier combinations are also applied, and so are coincident set and clear cycles.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;

    localparam int M_CAUSES = 2;
    localparam int S_CAUSES = 4;
    localparam int SEL_W    = 4;

    localparam int M_DONE  = 0;
    localparam int M_FAULT = 1;

    localparam int S_RX    = 0;
    localparam int S_TXQ   = 1;
    localparam int S_START = 2;
    localparam int S_STOP  = 3;

    localparam int FL_RREQ = 0;
    localparam int FL_TREQ = 1;
    localparam int FL_FBR  = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_MRAW  = 4'h0,
        SEL_MMASK = 4'h1,
        SEL_MCLR  = 4'h2,
        SEL_MSTAT = 4'h3,
        SEL_SRAW  = 4'h4,
        SEL_SMASK = 4'h5,
        SEL_SCLR  = 4'h6,
        SEL_SCSR  = 4'h7,
        SEL_SDATA = 4'h8
    } reg_sel_e;

endpackage

// File: rtl/i2c_line_watch.sv
module i2c_line_watch #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sda_i,
    input  logic scl_i,
    output logic start_o,
    output logic stop_o
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sda_sync;
        logic [SYNC_STAGES-1:0] scl_sync;
        logic                   sda_prev;
        logic                   scl_prev;
    } watch_t;

    watch_t st_d, st_q;
    logic   sda_s, scl_s;

    assign sda_s = st_q.sda_sync[SYNC_STAGES-1];
    assign scl_s = st_q.scl_sync[SYNC_STAGES-1];

    always_comb begin
        st_d          = st_q;
        st_d.sda_sync = {st_q.sda_sync[SYNC_STAGES-2:0], sda_i};
        st_d.scl_sync = {st_q.scl_sync[SYNC_STAGES-2:0], scl_i};
        st_d.sda_prev = sda_s;
        st_d.scl_prev = scl_s;
    end

    // Idle bus is high on both lines; reset there so no edge is seen.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign start_o = st_q.scl_prev & scl_s & st_q.sda_prev & ~sda_s;
    assign stop_o  = st_q.scl_prev & scl_s & ~st_q.sda_prev & sda_s;

endmodule

// File: rtl/i2c_irq_bank.sv
module i2c_irq_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         mask_wr_i,
    input  logic         clr_wr_i,
    input  logic [N-1:0] wdata_i,
    output logic [N-1:0] raw_o,
    output logic [N-1:0] mask_o,
    output logic         irq_o
);

    typedef struct packed {
        logic [N-1:0] raw;
        logic [N-1:0] mask;
    } bank_t;

    bank_t        st_d, st_q;
    logic [N-1:0] raw_nxt;

    // Per cause: a new event outranks a same-cycle clear.
    for (genvar i = 0; i < N; i++) begin : g_cause
        assign raw_nxt[i] = set_i[i] | (st_q.raw[i] & ~(clr_wr_i & wdata_i[i]));
    end

    always_comb begin
        st_d     = st_q;
        st_d.raw = raw_nxt;
        if (mask_wr_i) begin
            st_d.mask = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign raw_o  = st_q.raw;
    assign mask_o = st_q.mask;
    assign irq_o  = |(st_q.raw & st_q.mask);

endmodule

// File: rtl/i2c_irq_unit.sv
module i2c_irq_unit
    import i2c_irq_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              m_done,
    input  logic              m_nack,
    input  logic              m_arb_lost,
    input  logic              s_rx_byte,
    input  logic              s_rx_first,
    input  logic [DATA_W-1:0] s_rx_data,
    input  logic              s_tx_req,
    output logic [DATA_W-1:0] s_tx_data,
    input  logic              sda_in,
    input  logic              scl_in,
    output logic              m_irq,
    output logic              s_irq
);

    typedef struct packed {
        logic              m_err;
        logic              rreq;
        logic              treq;
        logic              fbr;
        logic [DATA_W-1:0] txdata;
    } unit_t;

    unit_t    st_d, st_q;
    reg_sel_e sel;
    logic     hit;
    logic     m_mask_wr, m_clr_wr, s_mask_wr, s_clr_wr, dat_rd, dat_wr;
    logic     bus_start, bus_stop;

    logic [M_CAUSES-1:0] m_set, m_raw, m_mask;
    logic [S_CAUSES-1:0] s_set, s_raw, s_mask;
    logic                flag_rreq, flag_treq, flag_fbr;

    // Register decode
    assign hit = (bus_addr >> SEL_W) == '0;
    assign sel = reg_sel_e'(bus_addr[SEL_W-1:0]);

    always_comb begin
        m_mask_wr = 1'b0;
        m_clr_wr  = 1'b0;
        s_mask_wr = 1'b0;
        s_clr_wr  = 1'b0;
        dat_rd    = 1'b0;
        dat_wr    = 1'b0;
        if (hit) begin
            case (sel)
                SEL_MMASK: m_mask_wr = bus_wr;
                SEL_MCLR:  m_clr_wr  = bus_wr;
                SEL_SMASK: s_mask_wr = bus_wr;
                SEL_SCLR:  s_clr_wr  = bus_wr;
                SEL_SDATA: begin
                    dat_rd = bus_rd;
                    dat_wr = bus_wr;
                end
                default: ;
            endcase
        end
    end

    // Bus condition watcher
    i2c_line_watch #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_watch (
        .clk    (clk),
        .rst_n  (rst_n),
        .sda_i  (sda_in),
        .scl_i  (scl_in),
        .start_o(bus_start),
        .stop_o (bus_stop)
    );

    // Event vectors
    always_comb begin
        m_set          = '0;
        m_set[M_DONE]  = m_done;
        m_set[M_FAULT] = m_done & (m_nack | m_arb_lost);
        s_set          = '0;
        s_set[S_RX]    = s_rx_byte;
        s_set[S_TXQ]   = s_tx_req;
        s_set[S_START] = bus_start;
        s_set[S_STOP]  = bus_stop;
    end

    i2c_irq_bank #(
        .N(M_CAUSES)
    ) u_mbank (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (m_set),
        .mask_wr_i(m_mask_wr),
        .clr_wr_i (m_clr_wr),
        .wdata_i  (bus_wdata[M_CAUSES-1:0]),
        .raw_o    (m_raw),
        .mask_o   (m_mask),
        .irq_o    (m_irq)
    );

    i2c_irq_bank #(
        .N(S_CAUSES)
    ) u_sbank (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (s_set),
        .mask_wr_i(s_mask_wr),
        .clr_wr_i (s_clr_wr),
        .wdata_i  (bus_wdata[S_CAUSES-1:0]),
        .raw_o    (s_raw),
        .mask_o   (s_mask),
        .irq_o    (s_irq)
    );

    // Master outcome and slave request flags
    always_comb begin
        st_d = st_q;
        if (m_done) begin
            st_d.m_err = m_nack | m_arb_lost;
        end
        st_d.rreq = s_rx_byte | (st_q.rreq & ~dat_rd);
        st_d.fbr  = (s_rx_byte & s_rx_first) | (st_q.fbr & ~dat_rd);
        st_d.treq = s_tx_req | (st_q.treq & ~dat_wr);
        if (dat_wr) begin
            st_d.txdata = bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_rreq = st_q.rreq;
    assign flag_treq = st_q.treq;
    assign flag_fbr  = st_q.fbr;
    assign s_tx_data = st_q.txdata;

    // Read mux
    always_comb begin
        bus_rdata = '0;
        if (hit) begin
            case (sel)
                SEL_MRAW:  bus_rdata = DATA_W'(m_raw);
                SEL_MMASK: bus_rdata = DATA_W'(m_mask);
                SEL_MSTAT: bus_rdata = DATA_W'(st_q.m_err);
                SEL_SRAW:  bus_rdata = DATA_W'(s_raw);
                SEL_SMASK: bus_rdata = DATA_W'(s_mask);
                SEL_SCSR: begin
                    bus_rdata[FL_RREQ] = st_q.rreq;
                    bus_rdata[FL_TREQ] = st_q.treq;
                    bus_rdata[FL_FBR]  = st_q.fbr;
                end
                SEL_SDATA: bus_rdata = s_rx_data;
                default:   bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/i2c_irq_sva.sv
module i2c_irq_sva #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              m_done,
    input logic              m_nack,
    input logic              m_arb_lost,
    input logic              s_rx_byte,
    input logic              s_rx_first,
    input logic [1:0]        m_raw,
    input logic [1:0]        m_mask,
    input logic [3:0]        s_raw,
    input logic [3:0]        s_mask,
    input logic              flag_rreq,
    input logic              flag_fbr,
    input logic              m_irq,
    input logic              s_irq
);

    logic s_clr_hit, dat_rd_hit;
    assign s_clr_hit  = bus_wr && (bus_addr == ADDR_W'(6));
    assign dat_rd_hit = bus_rd && (bus_addr == ADDR_W'(8));

    p_done_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        m_done |=> m_raw[0]);

    p_fault_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (m_done && (m_nack || m_arb_lost)) |=> m_raw[1]);

    p_rx_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        s_rx_byte |=> (s_raw[0] && flag_rreq));

    p_masked_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((m_mask == '0) |-> !m_irq) and ((s_mask == '0) |-> !s_irq));

    p_line_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        s_irq |-> ((s_raw & s_mask) != '0));

    p_clear_works_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_clr_hit && bus_wdata[0] && !s_rx_byte) |=> !s_raw[0]);

    p_set_beats_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_clr_hit && s_rx_byte) |=> s_raw[0]);

    p_fbr_implies_rreq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flag_fbr |-> flag_rreq);

    p_fbr_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_rx_byte && s_rx_first) |=> flag_fbr);

    p_data_read_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_rd_hit && !s_rx_byte) |=> (!flag_rreq && !flag_fbr));

endmodule

bind i2c_irq_unit i2c_irq_sva #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .m_done    (m_done),
    .m_nack    (m_nack),
    .m_arb_lost(m_arb_lost),
    .s_rx_byte (s_rx_byte),
    .s_rx_first(s_rx_first),
    .m_raw     (m_raw),
    .m_mask    (m_mask),
    .s_raw     (s_raw),
    .s_mask    (s_mask),
    .flag_rreq (flag_rreq),
    .flag_fbr  (flag_fbr),
    .m_irq     (m_irq),
    .s_irq     (s_irq)
);

// File: tb/tb_i2c_irq_unit.sv
module tb_i2c_irq_unit;

    localparam int AW = 4;
    localparam int DW = 8;

    localparam logic [AW-1:0] A_MRAW  = 4'h0;
    localparam logic [AW-1:0] A_MMASK = 4'h1;
    localparam logic [AW-1:0] A_MCLR  = 4'h2;
    localparam logic [AW-1:0] A_MSTAT = 4'h3;
    localparam logic [AW-1:0] A_SRAW  = 4'h4;
    localparam logic [AW-1:0] A_SMASK = 4'h5;
    localparam logic [AW-1:0] A_SCLR  = 4'h6;
    localparam logic [AW-1:0] A_SCSR  = 4'h7;
    localparam logic [AW-1:0] A_SDATA = 4'h8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          m_done = 1'b0, m_nack = 1'b0, m_arb_lost = 1'b0;
    logic          s_rx_byte = 1'b0, s_rx_first = 1'b0, s_tx_req = 1'b0;
    logic [DW-1:0] s_rx_data = '0;
    logic [DW-1:0] s_tx_data;
    logic          sda_in = 1'b1, scl_in = 1'b1;
    logic          m_irq, s_irq;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    i2c_irq_unit #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .m_done(m_done), .m_nack(m_nack), .m_arb_lost(m_arb_lost),
        .s_rx_byte(s_rx_byte), .s_rx_first(s_rx_first), .s_rx_data(s_rx_data),
        .s_tx_req(s_tx_req), .s_tx_data(s_tx_data), .sda_in(sda_in),
        .scl_in(scl_in), .m_irq(m_irq), .s_irq(s_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic m_pulse(input logic nk, input logic ab);
        @(negedge clk);
        m_done = 1'b1; m_nack = nk; m_arb_lost = ab;
        @(negedge clk);
        m_done = 1'b0; m_nack = 1'b0; m_arb_lost = 1'b0;
    endtask

    task automatic rx_pulse(input logic first);
        @(negedge clk);
        s_rx_byte = 1'b1; s_rx_first = first;
        @(negedge clk);
        s_rx_byte = 1'b0; s_rx_first = 1'b0;
    endtask

    task automatic tx_pulse();
        @(negedge clk);
        s_tx_req = 1'b1;
        @(negedge clk);
        s_tx_req = 1'b0;
    endtask

    task automatic line_start();
        @(negedge clk);
        scl_in = 1'b1; sda_in = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic line_stop();
        @(negedge clk);
        scl_in = 1'b1; sda_in = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic slave_fill();
        rx_pulse(1'b0);
        tx_pulse();
        line_start();
        line_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired R1 actual=timeout expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_MRAW, d);  chk("R1 mraw", d, 0);
        rd(A_MMASK, d); chk("R1 mmask", d, 0);
        rd(A_MSTAT, d); chk("R1 mstat", d, 0);
        rd(A_SRAW, d);  chk("R1 sraw", d, 0);
        rd(A_SMASK, d); chk("R1 smask", d, 0);
        rd(A_SCSR, d);  chk("R1 scsr", d, 0);
        chk("R1 m_irq", m_irq, 0);
        chk("R1 s_irq", s_irq, 0);

        // R2 all qualifier combinations
        for (int q = 0; q < 4; q++) begin
            wr(A_MCLR, 8'h03);
            m_pulse(q[0], q[1]);
            rd(A_MRAW, d);  chk("R2 raw", d, {6'd0, (q != 0), 1'b1});
            rd(A_MSTAT, d); chk("R2 status", d, (q != 0) ? 1 : 0);
        end
        chk("R6 master masked off", m_irq, 0);

        // R5 R6 master sweep: raw x mask
        for (int r = 0; r < 4; r++) begin
            for (int m = 0; m < 4; m++) begin
                m_pulse(1'b1, 1'b0);
                wr(A_MCLR, DW'((~r) & 3));
                wr(A_MMASK, DW'(m));
                rd(A_MRAW, d);  chk("R5 master raw readback", d, r);
                rd(A_MMASK, d); chk("R5 master mask readback", d, m);
                chk("R6 m_irq", m_irq, ((r & m) != 0) ? 1 : 0);
                chk("R6 s_irq isolated", s_irq, 0);
            end
        end
        wr(A_MMASK, 8'h00);

        // R3 R5 R6 R7 slave sweep: raw x mask
        for (int r = 0; r < 16; r++) begin
            slave_fill();
            rd(A_SRAW, d); chk("R3 all slave causes set", d, 8'h0F);
            wr(A_SCLR, DW'((~r) & 15));
            rd(A_SRAW, d); chk("R7 slave clear pattern", d, r);
            for (int m = 0; m < 16; m++) begin
                wr(A_SMASK, DW'(m));
                chk("R6 s_irq", s_irq, ((r & m) != 0) ? 1 : 0);
                chk("R6 m_irq isolated", m_irq, 0);
            end
        end
        rd(A_SDATA, d);
        wr(A_SDATA, 8'h00);
        wr(A_SMASK, 8'h00);

        // R4 START/STOP only while SCL high
        wr(A_SCLR, 8'h0F);
        @(negedge clk); scl_in = 1'b0;
        repeat (4) @(negedge clk);
        sda_in = 1'b0; repeat (5) @(negedge clk);
        sda_in = 1'b1; repeat (5) @(negedge clk);
        scl_in = 1'b1; repeat (5) @(negedge clk);
        rd(A_SRAW, d); chk("R4 sda edge with scl low", d, 0);
        line_start();
        rd(A_SRAW, d); chk("R4 start only", d, 8'h04);
        line_stop();
        rd(A_SRAW, d); chk("R4 stop added", d, 8'h0C);

        // R7 zeros ignored, clear reads 0
        wr(A_SCLR, 8'h00);
        rd(A_SRAW, d); chk("R7 zero write keeps", d, 8'h0C);
        rd(A_SCLR, d); chk("R7 slave clear reads 0", d, 0);
        rd(A_MCLR, d); chk("R7 master clear reads 0", d, 0);
        wr(A_SCLR, 8'h04);
        rd(A_SRAW, d); chk("R7 clear one bit", d, 8'h08);
        wr(A_SCLR, 8'h0F);

        // R8 event beats clear
        @(negedge clk);
        s_rx_byte = 1'b1; bus_addr = A_SCLR; bus_wdata = 8'h01; bus_wr = 1'b1;
        @(negedge clk);
        s_rx_byte = 1'b0; bus_wr = 1'b0;
        rd(A_SRAW, d); chk("R8 slave set wins", d, 8'h01);
        wr(A_MCLR, 8'h03);
        @(negedge clk);
        m_done = 1'b1; bus_addr = A_MCLR; bus_wdata = 8'h03; bus_wr = 1'b1;
        @(negedge clk);
        m_done = 1'b0; bus_wr = 1'b0;
        rd(A_MRAW, d); chk("R8 master set wins", d, 8'h01);

        // R9 R10 flags
        rd(A_SDATA, d);
        wr(A_SDATA, 8'h00);
        rd(A_SCSR, d); chk("R10 flags idle", d, 0);
        rx_pulse(1'b0);
        rd(A_SCSR, d); chk("R9 rreq without first", d, 8'h01);
        rd(A_SDATA, d);
        rd(A_SCSR, d); chk("R10 read clears rreq", d, 0);
        rx_pulse(1'b1);
        rd(A_SCSR, d); chk("R9 rreq and fbr together", d, 8'h05);
        tx_pulse();
        rd(A_SCSR, d); chk("R10 treq set", d, 8'h07);
        wr(A_SDATA, 8'h3C);
        rd(A_SCSR, d); chk("R10 write clears treq only", d, 8'h05);
        rd(A_SDATA, d);
        rd(A_SCSR, d); chk("R10 read clears rreq fbr", d, 0);
        @(negedge clk);
        s_rx_byte = 1'b1; bus_addr = A_SDATA; bus_rd = 1'b1;
        @(negedge clk);
        s_rx_byte = 1'b0; bus_rd = 1'b0;
        rd(A_SCSR, d); chk("R10 rreq set wins over read", d, 8'h01);
        rd(A_SDATA, d);

        // R11 data path
        s_rx_data = 8'hA5;
        rd(A_SDATA, d); chk("R11 rx data read", d, 8'hA5);
        s_rx_data = 8'h5A;
        rd(A_SDATA, d); chk("R11 rx data read 2", d, 8'h5A);
        chk("R11 tx data", s_tx_data, 8'h3C);
        wr(A_SDATA, 8'hC3);
        chk("R11 tx data 2", s_tx_data, 8'hC3);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule